// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts, for each memory instruction entering an out-of-order core, which older in-flight store it should wait behind. It keeps two tables. The first is indexed by instruction address and maps an instruction to a dependence-set number. The second is indexed by that set number and holds the sequence number and thread of the most recently fetched store in the set. A lookup walks both tables in the same cycle and returns the store's sequence number, or zero when there is nothing to wait for. Sequence number zero is reserved and never names a store.

Sets form through ordering-violation reports. A report carries the address of a store and the address of the load that overtook it; the two are joined into one set. Store insertions fill the second table, store issue notifications and per-thread squashes empty it, and a load insertion leaves everything as it was. To keep sets from growing until every store looks dependent, the block counts lookups and wipes all valid bits when the count reaches a programmable period. An explicit clear command does the same wipe.

One lookup and one table command may be given each cycle. The lookup result is combinational and reflects the tables before the command of that cycle takes effect. All table updates occur on the rising clock edge.

Top module: `memdep_predictor`

## Requirements
- R1: After reset every entry of both tables is invalid, so every lookup returns 0 and the lookup counter starts at 0.
- R2: With `lookup_valid` high, `dep_seq` equals the stored sequence number of the second-table entry named by the first-table entry at index (`lookup_pc` >> PC_SHIFT) & (SET_ENTRIES-1); it is 0 when either entry is invalid, and 0 whenever `lookup_valid` is low. The result is combinational and shows the table state before the same cycle's command.
- R3: A violation report (`cmd_op` = 4, store address `cmd_pc`, load address `cmd_pc2`) in which neither address has a valid first-table entry gives both entries the set number (`cmd_pc` XOR (`cmd_pc` >> 10)) modulo LAST_ENTRIES and marks them valid.
- R4: A violation report in which exactly one of the two addresses has a valid first-table entry copies that entry's set number into the other address's entry and marks it valid.
- R5: A violation report in which both addresses have valid first-table entries writes the smaller of the two set numbers into both.
- R6: A store insertion (`cmd_op` = 1) with a valid first-table entry for `cmd_pc` and a nonzero `cmd_seq` writes `cmd_seq` and `cmd_tid` into the set's second-table entry and marks it valid; with an invalid first-table entry or with `cmd_seq` = 0 it changes nothing.
- R7: A load insertion (`cmd_op` = 2), the idle code 0 and the spare code 7 change no table state.
- R8: A store issue notification (`cmd_op` = 3) invalidates the second-table entry of `cmd_pc`'s set only when that entry is valid and holds exactly `cmd_seq`.
- R9: A squash (`cmd_op` = 5) invalidates every second-table entry whose thread equals `cmd_tid` and whose sequence number is greater than `cmd_seq`; entries of other threads and older entries stay.
- R10: Every cycle with `lookup_valid` high counts one lookup; when `clear_period` is nonzero and the count including this lookup reaches at least `clear_period`, all valid bits of both tables are cleared at that edge, the same cycle's command is dropped and the count restarts at 0. A `clear_period` of 0 never triggers a wipe.
- R11: A clear command (`cmd_op` = 6) clears every valid bit of both tables in one cycle and restarts the lookup count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_period | input | PERIOD_W | Lookups between automatic wipes; 0 disables |
| lookup_valid | input | 1 | A dependence lookup is requested this cycle |
| lookup_pc | input | PC_W | Address of the instruction being looked up |
| cmd_op | input | 3 | Command: 0 idle, 1 store insert, 2 load insert, 3 store issued, 4 violation, 5 squash, 6 clear, 7 spare |
| cmd_pc | input | PC_W | Store address for commands 1, 3 and 4 |
| cmd_pc2 | input | PC_W | Load address for a violation report |
| cmd_seq | input | SEQ_W | Sequence number for commands 1, 3 and 5 |
| cmd_tid | input | TID_W | Thread for commands 1 and 5 |
| dep_seq | output | SEQ_W | Sequence number of the store to wait for, 0 for none |

## Verification
The bench first sweeps every first-table index on an empty predictor, then drives a sequence of violation reports whose store and load addresses rotate through the index space so that the fresh-set, adopt-set and merge-to-smaller cases of a report each occur, and follows every report with store insertions and lookups of both addresses, which tells apart a wrong set assignment from a wrong second-table write. Issue notifications with matching and non-matching sequence numbers separate a correct compare from an unconditional invalidate, and squashes across two threads separate the thread filter and the strict younger-than compare from looser variants. A long pseudo-random mix of all command codes over a small address pool, first with the periodic wipe disabled and then with a short period, checks every cycle's lookup against an arithmetic model so that wipe timing, dropped commands and counter restart show up as a mismatched lookup.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

    // Table command codes carried on cmd_op.
    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_ST_INSERT = 3'd1,
        OP_LD_INSERT = 3'd2,
        OP_ST_ISSUED = 3'd3,
        OP_VIOLATION = 3'd4,
        OP_SQUASH    = 3'd5,
        OP_CLEAR     = 3'd6,
        OP_SPARE     = 3'd7
    } op_e;

endpackage

// File: rtl/memdep_set_table.sv
// First-level table: instruction index -> dependence-set number.
module memdep_set_table #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [ID_W-1:0]  look_id,
    input  logic [IDX_W-1:0] st_idx,
    output logic             st_valid,
    output logic [ID_W-1:0]  st_id,
    input  logic [IDX_W-1:0] ld_idx,
    output logic             ld_valid,
    output logic [ID_W-1:0]  ld_id,
    input  logic             wr_st_en,
    input  logic [ID_W-1:0]  wr_st_id,
    input  logic             wr_ld_en,
    input  logic [ID_W-1:0]  wr_ld_id
);

    logic [DEPTH-1:0] vld;
    logic [ID_W-1:0]  ids [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic            v_q;
        logic [ID_W-1:0] id_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q  <= 1'b0;
                id_q <= '0;
            end else if (wipe) begin
                v_q  <= 1'b0;
            end else if (wr_ld_en && ld_idx == IDX_W'(e)) begin
                v_q  <= 1'b1;
                id_q <= wr_ld_id;
            end else if (wr_st_en && st_idx == IDX_W'(e)) begin
                v_q  <= 1'b1;
                id_q <= wr_st_id;
            end
        end

        assign vld[e] = v_q;
        assign ids[e] = id_q;
    end

    assign look_valid = vld[look_idx];
    assign look_id    = ids[look_idx];
    assign st_valid   = vld[st_idx];
    assign st_id      = ids[st_idx];
    assign ld_valid   = vld[ld_idx];
    assign ld_id      = ids[ld_idx];

endmodule

// File: rtl/memdep_last_store.sv
// Second-level table: set number -> last fetched store (sequence, thread).
module memdep_last_store #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int TID_W = 1,
    localparam int ID_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic [ID_W-1:0]  look_id,
    output logic             look_valid,
    output logic [SEQ_W-1:0] look_seq,
    input  logic             ins_en,
    input  logic [ID_W-1:0]  ins_id,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [TID_W-1:0] ins_tid,
    input  logic             iss_en,
    input  logic [ID_W-1:0]  iss_id,
    input  logic [SEQ_W-1:0] iss_seq,
    input  logic             sq_en,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq
);

    logic [DEPTH-1:0] vld;
    logic [SEQ_W-1:0] seqs [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic             v_q;
        logic [SEQ_W-1:0] seq_q;
        logic [TID_W-1:0] tid_q;
        logic             iss_hit;
        logic             sq_hit;

        assign iss_hit = iss_en && iss_id == ID_W'(e) && v_q && seq_q == iss_seq;
        assign sq_hit  = sq_en && v_q && tid_q == sq_tid && seq_q > sq_seq;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                seq_q <= '0;
                tid_q <= '0;
            end else if (wipe) begin
                v_q   <= 1'b0;
            end else if (ins_en && ins_id == ID_W'(e)) begin
                v_q   <= 1'b1;
                seq_q <= ins_seq;
                tid_q <= ins_tid;
            end else if (iss_hit || sq_hit) begin
                v_q   <= 1'b0;
            end
        end

        assign vld[e]  = v_q;
        assign seqs[e] = seq_q;
    end

    assign look_valid = vld[look_id];
    assign look_seq   = seqs[look_id];

endmodule

// File: rtl/memdep_wipe_timer.sv
// Counts lookups and raises a one-cycle wipe at the programmed period.
module memdep_wipe_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             force_clr,
    output logic             wipe
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;
    logic             limit_hit;

    assign cnt_next  = {1'b0, cnt_q} + 1'b1;
    assign limit_hit = tick && (period != '0) && (cnt_next >= {1'b0, period});
    assign wipe      = force_clr || limit_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wipe) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/memdep_predictor.sv
module memdep_predictor
    import memdep_pkg::*;
#(
    parameter int PC_W         = 16,
    parameter int SEQ_W        = 8,
    parameter int TID_W        = 1,
    parameter int SET_ENTRIES  = 16,
    parameter int LAST_ENTRIES = 8,
    parameter int PC_SHIFT     = 2,
    parameter int PERIOD_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] clear_period,
    input  logic                lookup_valid,
    input  logic [PC_W-1:0]     lookup_pc,
    input  logic [2:0]          cmd_op,
    input  logic [PC_W-1:0]     cmd_pc,
    input  logic [PC_W-1:0]     cmd_pc2,
    input  logic [SEQ_W-1:0]    cmd_seq,
    input  logic [TID_W-1:0]    cmd_tid,
    output logic [SEQ_W-1:0]    dep_seq
);

    localparam int SIDX_W = $clog2(SET_ENTRIES);
    localparam int ID_W   = $clog2(LAST_ENTRIES);

    // Set number given to a pair that has no set yet.
    function automatic logic [ID_W-1:0] fresh_set(input logic [PC_W-1:0] pc);
        logic [PC_W-1:0] mix;
        mix = pc ^ (pc >> 10);
        return ID_W'(mix % PC_W'(LAST_ENTRIES));
    endfunction

    function automatic logic [SIDX_W-1:0] set_index(input logic [PC_W-1:0] pc);
        return SIDX_W'((pc >> PC_SHIFT) & PC_W'(SET_ENTRIES - 1));
    endfunction

    op_e              op;
    logic [SIDX_W-1:0] look_idx, st_idx, ld_idx;
    logic             look_sv, st_sv, ld_sv;
    logic [ID_W-1:0]  look_id, st_id, ld_id;
    logic             wr_st_en, wr_ld_en;
    logic [ID_W-1:0]  wr_st_id, wr_ld_id;
    logic             ins_en, iss_en, sq_en, clr_req;
    logic             wipe;
    logic             look_lv;
    logic [SEQ_W-1:0] look_seq;
    logic [ID_W-1:0]  hash_id, low_id;

    assign op       = op_e'(cmd_op);
    assign look_idx = set_index(lookup_pc);
    assign st_idx   = set_index(cmd_pc);
    assign ld_idx   = set_index(cmd_pc2);
    assign hash_id  = fresh_set(cmd_pc);
    assign low_id   = (st_id < ld_id) ? st_id : ld_id;

    // Command decode into table write enables.
    always_comb begin
        wr_st_en = 1'b0;
        wr_ld_en = 1'b0;
        wr_st_id = '0;
        wr_ld_id = '0;
        ins_en   = 1'b0;
        iss_en   = 1'b0;
        sq_en    = 1'b0;
        clr_req  = 1'b0;
        unique case (op)
            OP_IDLE, OP_LD_INSERT, OP_SPARE: ;
            OP_ST_INSERT: ins_en = st_sv && (cmd_seq != '0);
            OP_ST_ISSUED: iss_en = st_sv;
            OP_VIOLATION: begin
                unique case ({st_sv, ld_sv})
                    2'b00: begin
                        wr_st_en = 1'b1;
                        wr_ld_en = 1'b1;
                        wr_st_id = hash_id;
                        wr_ld_id = hash_id;
                    end
                    2'b10: begin
                        wr_ld_en = 1'b1;
                        wr_ld_id = st_id;
                    end
                    2'b01: begin
                        wr_st_en = 1'b1;
                        wr_st_id = ld_id;
                    end
                    default: begin
                        wr_st_en = 1'b1;
                        wr_ld_en = 1'b1;
                        wr_st_id = low_id;
                        wr_ld_id = low_id;
                    end
                endcase
            end
            OP_SQUASH: sq_en = 1'b1;
            OP_CLEAR:  clr_req = 1'b1;
        endcase
    end

    memdep_set_table #(
        .DEPTH (SET_ENTRIES),
        .ID_W  (ID_W)
    ) u_set_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .look_idx   (look_idx),
        .look_valid (look_sv),
        .look_id    (look_id),
        .st_idx     (st_idx),
        .st_valid   (st_sv),
        .st_id      (st_id),
        .ld_idx     (ld_idx),
        .ld_valid   (ld_sv),
        .ld_id      (ld_id),
        .wr_st_en   (wr_st_en),
        .wr_st_id   (wr_st_id),
        .wr_ld_en   (wr_ld_en),
        .wr_ld_id   (wr_ld_id)
    );

    memdep_last_store #(
        .DEPTH (LAST_ENTRIES),
        .SEQ_W (SEQ_W),
        .TID_W (TID_W)
    ) u_last_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wipe       (wipe),
        .look_id    (look_id),
        .look_valid (look_lv),
        .look_seq   (look_seq),
        .ins_en     (ins_en),
        .ins_id     (st_id),
        .ins_seq    (cmd_seq),
        .ins_tid    (cmd_tid),
        .iss_en     (iss_en),
        .iss_id     (st_id),
        .iss_seq    (cmd_seq),
        .sq_en      (sq_en),
        .sq_tid     (cmd_tid),
        .sq_seq     (cmd_seq)
    );

    memdep_wipe_timer #(
        .CNT_W (PERIOD_W)
    ) u_wipe_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (lookup_valid),
        .period    (clear_period),
        .force_clr (clr_req),
        .wipe      (wipe)
    );

    assign dep_seq = (lookup_valid && look_sv && look_lv) ? look_seq : '0;

endmodule

// File: rtl/memdep_checker.sv
module memdep_checker
    import memdep_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int SEQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_op,
    input logic [PC_W-1:0]  cmd_pc,
    input logic [SEQ_W-1:0] cmd_seq,
    input logic             lookup_valid,
    input logic [PC_W-1:0]  lookup_pc,
    input logic [SEQ_W-1:0] dep_seq,
    input logic             wipe
);

    // R1: first cycle out of reset sees empty tables
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dep_seq == '0);

    // R10: a wipe leaves nothing for the next lookup to find
    assert_wipe_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> dep_seq == '0);

    // R11: the clear command empties the tables in one cycle
    assert_clear_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_CLEAR) |=> dep_seq == '0);

    // R8: an issued store that matched is no longer predicted
    assert_issue_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ST_ISSUED && lookup_valid && lookup_pc == cmd_pc &&
         dep_seq == cmd_seq && dep_seq != '0)
        |=> (!lookup_valid || lookup_pc != $past(lookup_pc) || dep_seq == '0));

    // R7: a load insertion leaves the prediction unchanged
    assert_load_insert_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_LD_INSERT && !wipe && lookup_valid)
        |=> (!lookup_valid || lookup_pc != $past(lookup_pc) || dep_seq == $past(dep_seq)));

    // R6: a store insertion with sequence 0 changes nothing
    assert_zero_seq_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ST_INSERT && cmd_seq == '0 && !wipe && lookup_valid)
        |=> (!lookup_valid || lookup_pc != $past(lookup_pc) || dep_seq == $past(dep_seq)));

endmodule

bind memdep_predictor memdep_checker #(
    .PC_W  (PC_W),
    .SEQ_W (SEQ_W)
) u_memdep_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_op       (cmd_op),
    .cmd_pc       (cmd_pc),
    .cmd_seq      (cmd_seq),
    .lookup_valid (lookup_valid),
    .lookup_pc    (lookup_pc),
    .dep_seq      (dep_seq),
    .wipe         (wipe)
);

// File: tb/memdep_predictor_bench.sv
module memdep_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 16;
    localparam int LASTS = 8;
    localparam int SHIFT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] clear_period = '0;
    logic        lookup_valid = 1'b0;
    logic [15:0] lookup_pc = '0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_pc = '0;
    logic [15:0] cmd_pc2 = '0;
    logic [7:0]  cmd_seq = '0;
    logic [0:0]  cmd_tid = '0;
    logic [7:0]  dep_seq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference state
    bit m_sv [SETS];
    int m_sid[SETS];
    bit m_lv [LASTS];
    int m_seq[LASTS];
    int m_tid[LASTS];
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memdep_predictor u_memdep_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_period (clear_period),
        .lookup_valid (lookup_valid),
        .lookup_pc    (lookup_pc),
        .cmd_op       (cmd_op),
        .cmd_pc       (cmd_pc),
        .cmd_pc2      (cmd_pc2),
        .cmd_seq      (cmd_seq),
        .cmd_tid      (cmd_tid),
        .dep_seq      (dep_seq)
    );

    function automatic int idx_of(int pc);
        return (pc >> SHIFT) & (SETS - 1);
    endfunction

    function automatic int hash_of(int pc);
        return ((pc ^ (pc >> 10)) & 16'hFFFF) % LASTS;
    endfunction

    function automatic int model_look(int pc);
        int i;
        i = idx_of(pc);
        if (!m_sv[i]) return 0;
        if (!m_lv[m_sid[i]]) return 0;
        return m_seq[m_sid[i]];
    endfunction

    function automatic string viol_case(int spc, int lpc);
        bit a, b;
        a = m_sv[idx_of(spc)];
        b = m_sv[idx_of(lpc)];
        if (!a && !b) return "R3";
        if (a && b) return "R5";
        return "R4";
    endfunction

    task automatic model_apply(int op, int pc, int pc2, int seq, int tid, bit lv);
        int si, li, id, mn;
        bit wipe;
        wipe = (op == 6) || (lv && clear_period != 0 && m_cnt + 1 >= int'(clear_period));
        if (wipe) begin
            for (int j = 0; j < SETS; j++) m_sv[j] = 1'b0;
            for (int j = 0; j < LASTS; j++) m_lv[j] = 1'b0;
            m_cnt = 0;
            return;
        end
        if (lv) m_cnt++;
        si = idx_of(pc);
        li = idx_of(pc2);
        case (op)
            1: if (m_sv[si] && seq != 0) begin
                id = m_sid[si];
                m_lv[id] = 1'b1; m_seq[id] = seq; m_tid[id] = tid;
            end
            3: if (m_sv[si]) begin
                id = m_sid[si];
                if (m_lv[id] && m_seq[id] == seq) m_lv[id] = 1'b0;
            end
            4: begin
                if (!m_sv[si] && !m_sv[li]) begin
                    m_sid[si] = hash_of(pc); m_sid[li] = hash_of(pc);
                    m_sv[si] = 1'b1; m_sv[li] = 1'b1;
                end else if (m_sv[si] && !m_sv[li]) begin
                    m_sid[li] = m_sid[si]; m_sv[li] = 1'b1;
                end else if (!m_sv[si] && m_sv[li]) begin
                    m_sid[si] = m_sid[li]; m_sv[si] = 1'b1;
                end else begin
                    mn = (m_sid[si] < m_sid[li]) ? m_sid[si] : m_sid[li];
                    m_sid[si] = mn; m_sid[li] = mn;
                end
            end
            5: for (int j = 0; j < LASTS; j++)
                if (m_lv[j] && m_tid[j] == tid && m_seq[j] > seq) m_lv[j] = 1'b0;
            default: ;
        endcase
    endtask

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: dep_seq=%0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive command and lookup, check the lookup, advance model.
    task automatic step(int op, int pc, int pc2, int seq, int tid, bit lv, int lpc, string tag);
        int exp;
        @(negedge clk);
        cmd_op       = 3'(op);
        cmd_pc       = 16'(pc);
        cmd_pc2      = 16'(pc2);
        cmd_seq      = 8'(seq);
        cmd_tid      = 1'(tid);
        lookup_valid = lv;
        lookup_pc    = 16'(lpc);
        #1;
        exp = lv ? model_look(lpc) : 0;
        check(tag, int'(dep_seq), exp);
        model_apply(op, pc, pc2, seq, tid, lv);
    endtask

    task automatic look(int pc, string tag);
        step(0, 0, 0, 0, 0, 1'b1, pc, tag);
    endtask

    initial begin
        string tag;
        for (int j = 0; j < SETS; j++) begin m_sv[j] = 0; m_sid[j] = 0; end
        for (int j = 0; j < LASTS; j++) begin m_lv[j] = 0; m_seq[j] = 0; m_tid[j] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every index empty after reset
        for (int i = 0; i < SETS; i++) look(i << SHIFT, "R1 empty after reset");

        // R2: no lookup gives zero
        step(0, 0, 0, 0, 0, 1'b0, 0, "R2 idle output");

        // R6: store with no set is not recorded
        step(1, 16'h0004, 0, 5, 0, 1'b1, 16'h0004, "R6 insert without set");
        look(16'h0004, "R6 insert without set");

        // R3/R4/R5: rotating violation sweep
        for (int k = 0; k < SETS; k++) begin
            int spc, lpc;
            spc = k * 4 + k * 1024;
            lpc = ((k + 5) % SETS) * 4;
            tag = viol_case(spc, lpc);
            step(4, spc, lpc, 0, 0, 1'b1, lpc, tag);
            step(1, spc, 0, k + 1, k % 2, 1'b1, lpc, tag);
            look(lpc, tag);
            look(spc, tag);
        end
        // R5: join two already-valid addresses from different sets
        step(4, 16'h0008, 16'h003C, 0, 0, 1'b1, 16'h0008, viol_case(16'h0008, 16'h003C));
        step(1, 16'h0008, 0, 77, 0, 1'b1, 16'h003C, "R5 merged set");
        look(16'h003C, "R5 merged set");

        // R7: load insertion and spare code leave predictions alone
        step(2, 16'h003C, 0, 99, 1, 1'b1, 16'h003C, "R7 load insert");
        step(7, 16'h003C, 16'h0010, 99, 1, 1'b1, 16'h003C, "R7 spare code");
        look(16'h003C, "R7 after inert commands");

        // R6: sequence 0 not recorded
        step(1, 16'h0008, 0, 0, 0, 1'b1, 16'h0008, "R6 zero sequence");
        look(16'h0008, "R6 zero sequence");

        // R8: mismatching issue keeps, matching issue removes
        step(1, 16'h0008, 0, 40, 0, 1'b1, 16'h0008, "R8 setup");
        step(3, 16'h0008, 0, 41, 0, 1'b1, 16'h0008, "R8 mismatched issue");
        look(16'h0008, "R8 mismatched issue");
        step(3, 16'h0008, 0, 40, 0, 1'b1, 16'h0008, "R8 matching issue");
        look(16'h0008, "R8 matching issue");

        // R9: squash by thread and age
        for (int k = 0; k < SETS; k++) step(1, k * 4, 0, 20 + k, k % 2, 1'b0, 0, "R9 setup");
        step(5, 0, 0, 27, 0, 1'b0, 0, "R9 squash thread 0");
        for (int k = 0; k < SETS; k++) look(k * 4, "R9 after squash");
        step(5, 0, 0, 27, 1, 1'b0, 0, "R9 squash thread 1");
        for (int k = 0; k < SETS; k++) look(k * 4, "R9 after second squash");

        // R11: clear command
        step(6, 0, 0, 0, 0, 1'b1, 16'h0004, "R11 clear");
        for (int k = 0; k < SETS; k++) look(k * 4, "R11 after clear");

        // R2: pseudo-random mix, wipe disabled
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 8);
            if (op == 6 && ($urandom % 8) != 0) op = 1;
            step(op, int'($urandom % 16) * 4 + int'($urandom % 4) * 1024,
                 int'($urandom % 16) * 4, int'($urandom % 32), int'($urandom % 2),
                 1'($urandom % 2), int'($urandom % 16) * 4, "R2 mixed traffic");
        end

        // R10: periodic wipe with a short period
        clear_period = 16'd5;
        step(6, 0, 0, 0, 0, 1'b0, 0, "R10 restart count");
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 8);
            if (op == 6) op = 4;
            step(op, int'($urandom % 8) * 4, int'($urandom % 8) * 4,
                 int'($urandom % 32), int'($urandom % 2),
                 1'(($urandom % 4) == 0), int'($urandom % 8) * 4, "R10 periodic wipe");
        end
        // R10: period of 1 wipes on every lookup
        clear_period = 16'd1;
        step(4, 16'h0004, 16'h0008, 0, 0, 1'b0, 0, "R10 setup");
        step(1, 16'h0004, 0, 9, 0, 1'b1, 16'h0008, "R10 period one");
        look(16'h0008, "R10 period one");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule